// File: doc/BRIEF.md
# MII PTP Event Frame Detector

This block listens without interfering on one direction of a 4-bit MII link, in the PHY clock domain. It looks for the start-of-frame delimiter. After it finds one, it puts the following nibbles back together into bytes and passes over the two 6-byte MAC addresses. It then checks the type field against the precision-time-protocol EtherType 0x88F7.

When the type field matches, the block raises a flag for one MII clock. A toggle handshake carries that event into the system clock domain, where it comes out as a pulse one system clock wide. A chip uses one instance on the transmit side and a second on the receive side. Firmware or timestamp logic then knows that a time-protocol frame has crossed the wire.

Top module: `mii_ptp_event_detector`

## Requirements
- R1: While rst_ni is low, and right after it rises, both pulse outputs are low and the detector is hunting for a delimiter.
- R2: A byte is only recognised after the delimiter. The delimiter is a 0x5 nibble followed by a 0xD nibble while valid is high. A frame that has the right type field at the right offset but no delimiter gives no pulse.
- R3: Each byte is built from two nibbles, low nibble first. The nibble sequence 7,F makes byte 0xF7. If the two nibbles of the last type byte are sent in the opposite order, no pulse results.
- R4: Exactly 12 bytes after the delimiter are skipped. The type field is bytes 12 and 13, counted from 0. A 0x88F7 pair at offset 11 or 13 gives no pulse.
- R5: When byte 12 is 0x88 and byte 13 is 0xF7, ptp_pulse_mii_o is high for exactly one MII clock. That clock is the one after the rising edge that samples the last nibble of byte 13.
- R6: A frame gives at most one pulse, even if more 0x88F7 pairs follow later in the same frame.
- R7: If byte 12 is not 0x88, the frame gives no pulse, even if later bytes hold 0x88F7.
- R8: Dropping mii_dv_i, even for a single clock, sends the detector back to hunting. The rest of that frame gives no pulse until a new delimiter is seen. A complete frame after that is detected normally.
- R9: Each MII-domain pulse produces exactly one ptp_pulse_sys_o pulse, one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mii_clk_i | input | 1 | MII clock of the monitored direction |
| sys_clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| mii_dv_i | input | 1 | Nibble-valid qualifier (data valid or transmit enable) |
| mii_d_i | input | 4 | MII data nibble |
| ptp_pulse_mii_o | output | 1 | One-cycle match pulse in the MII domain |
| ptp_pulse_sys_o | output | 1 | One-cycle match pulse in the system domain |

## Verification
A wrong byte counter or a wrong nibble phase would show up as a missing pulse on a correct frame, or as a pulse on a frame with the type field off by one byte. The error is visible one MII clock after the last type nibble. A state machine that fails to leave its done state, or fails to clear on a valid gap, would show up as extra pulses in the same frame or as lost pulses in the next frame. A broken toggle path would show up within three system clocks of the MII pulse, as a system pulse that is missing, doubled or wider than one cycle.

// File: rtl/ptp_det_pkg.sv
package ptp_det_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_TYPE_HI,
    ST_TYPE_LO,
    ST_DONE
  } det_state_e;
endpackage

// File: rtl/ptp_nibble_pair.sv
module ptp_nibble_pair #(
  parameter int NIB_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dv_i,
  input  logic [NIB_W-1:0]   nib_i,
  input  logic               align_i,
  output logic               byte_vld_o,
  output logic [2*NIB_W-1:0] byte_o
);
  logic             phase_q;
  logic [NIB_W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else if (!dv_i || align_i) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) low_q <= nib_i;
    end
  end

  assign byte_vld_o = dv_i & phase_q;
  assign byte_o     = {nib_i, low_q};
endmodule

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser
  import ptp_det_pkg::*;
#(
  parameter int          NIB_W     = 4,
  parameter int          HDR_BYTES = 12,
  parameter logic [15:0] ETYPE     = 16'h88F7,
  parameter logic [7:0]  SFD       = 8'hD5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dv_i,
  input  logic [NIB_W-1:0]   nib_i,
  input  logic               byte_vld_i,
  input  logic [2*NIB_W-1:0] byte_i,
  output logic               align_o,
  output logic               hit_o
);
  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HDR_BYTES - 1);

  det_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NIB_W-1:0] prev_q;
  logic             prev_vld_q;
  logic             hit_q, hit_d;
  logic             sfd_seen;

  assign sfd_seen = (state_q == ST_HUNT) && dv_i && prev_vld_q &&
                    (prev_q == SFD[NIB_W-1:0]) && (nib_i == SFD[2*NIB_W-1:NIB_W]);
  assign align_o  = sfd_seen;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hit_d   = 1'b0;
    if (!dv_i) begin
      state_d = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_HUNT: if (sfd_seen) begin
          state_d = ST_HDR;
          cnt_d   = '0;
        end
        ST_HDR: if (byte_vld_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_d = ST_TYPE_HI;
        end
        ST_TYPE_HI: if (byte_vld_i)
          state_d = (byte_i == ETYPE[15:8]) ? ST_TYPE_LO : ST_DONE;
        ST_TYPE_LO: if (byte_vld_i) begin
          hit_d   = (byte_i == ETYPE[7:0]);
          state_d = ST_DONE;
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      cnt_q      <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      prev_q     <= nib_i;
      prev_vld_q <= dv_i;
      hit_q      <= hit_d;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/ptp_toggle_sync.sv
module ptp_toggle_sync #(
  parameter int STAGES = 3
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o
);
  logic              tog_q;
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (pulse_i) tog_q <= ~tog_q;
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= tog_q;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge dst_clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] ^ sync_q[STAGES-2];
endmodule

// File: rtl/mii_ptp_event_detector.sv
module mii_ptp_event_detector #(
  parameter int          NIB_W       = 4,
  parameter int          HDR_BYTES   = 12,
  parameter logic [15:0] ETYPE       = 16'h88F7,
  parameter logic [7:0]  SFD         = 8'hD5,
  parameter int          SYNC_STAGES = 3
) (
  input  logic             mii_clk_i,
  input  logic             sys_clk_i,
  input  logic             rst_ni,
  input  logic             mii_dv_i,
  input  logic [NIB_W-1:0] mii_d_i,
  output logic             ptp_pulse_mii_o,
  output logic             ptp_pulse_sys_o
);
  localparam int BYTE_W = 2 * NIB_W;

  logic              align;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_val;

  ptp_nibble_pair #(.NIB_W(NIB_W)) u_pair (
    .clk_i     (mii_clk_i),
    .rst_ni    (rst_ni),
    .dv_i      (mii_dv_i),
    .nib_i     (mii_d_i),
    .align_i   (align),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_val)
  );

  ptp_frame_parser #(
    .NIB_W(NIB_W), .HDR_BYTES(HDR_BYTES), .ETYPE(ETYPE), .SFD(SFD)
  ) u_parse (
    .clk_i     (mii_clk_i),
    .rst_ni    (rst_ni),
    .dv_i      (mii_dv_i),
    .nib_i     (mii_d_i),
    .byte_vld_i(byte_vld),
    .byte_i    (byte_val),
    .align_o   (align),
    .hit_o     (ptp_pulse_mii_o)
  );

  ptp_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .src_clk_i(mii_clk_i),
    .dst_clk_i(sys_clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (ptp_pulse_mii_o),
    .pulse_o  (ptp_pulse_sys_o)
  );
endmodule

// File: rtl/mii_ptp_event_detector_chk.sv
module mii_ptp_event_detector_chk (
  input logic mii_clk_i,
  input logic sys_clk_i,
  input logic rst_ni,
  input logic mii_dv_i,
  input logic ptp_pulse_mii_o,
  input logic ptp_pulse_sys_o
);
  logic seen_q;

  always_ff @(posedge mii_clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= 1'b0;
    else if (!mii_dv_i)       seen_q <= 1'b0;
    else if (ptp_pulse_mii_o) seen_q <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge mii_clk_i)
    !rst_ni |-> !ptp_pulse_mii_o);

  // R5
  mii_pulse_width_chk: assert property (@(posedge mii_clk_i) disable iff (!rst_ni)
    ptp_pulse_mii_o |=> !ptp_pulse_mii_o);

  // R6
  one_per_frame_chk: assert property (@(posedge mii_clk_i) disable iff (!rst_ni)
    ptp_pulse_mii_o |-> !seen_q);

  // R8
  dv_gap_quiet_chk: assert property (@(posedge mii_clk_i) disable iff (!rst_ni)
    !mii_dv_i |=> !ptp_pulse_mii_o);

  // R9
  sys_pulse_width_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    ptp_pulse_sys_o |=> !ptp_pulse_sys_o);
endmodule

bind mii_ptp_event_detector mii_ptp_event_detector_chk u_chk (
  .mii_clk_i      (mii_clk_i),
  .sys_clk_i      (sys_clk_i),
  .rst_ni         (rst_ni),
  .mii_dv_i       (mii_dv_i),
  .ptp_pulse_mii_o(ptp_pulse_mii_o),
  .ptp_pulse_sys_o(ptp_pulse_sys_o)
);

// File: tb/sim_mii_ptp_event_detector.sv
module sim_mii_ptp_event_detector;
  localparam int CLK_PERIOD = 10;
  localparam int MII_PERIOD = 40;

  logic mii_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic mii_dv = 1'b0;
  logic [3:0] mii_d = 4'h0;
  logic pulse_mii, pulse_sys;

  int checks = 0, fails = 0;
  int mii_cnt = 0, sys_cnt = 0, sys_run = 0, sys_max_run = 0;
  bit done = 1'b0;

  always #(MII_PERIOD/2) mii_clk = ~mii_clk;
  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  mii_ptp_event_detector u0 (
    .mii_clk_i(mii_clk), .sys_clk_i(sys_clk), .rst_ni(rst_n),
    .mii_dv_i(mii_dv), .mii_d_i(mii_d),
    .ptp_pulse_mii_o(pulse_mii), .ptp_pulse_sys_o(pulse_sys)
  );

  always @(negedge mii_clk) if (pulse_mii) mii_cnt++;
  always @(negedge sys_clk) begin
    if (pulse_sys) begin
      sys_cnt++;
      sys_run++;
      if (sys_run > sys_max_run) sys_max_run = sys_run;
    end else sys_run = 0;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nib(input logic [3:0] n);
    @(negedge mii_clk);
    mii_d  = n;
    mii_dv = 1'b1;
  endtask

  task automatic byte_out(input logic [7:0] b);
    nib(b[3:0]);
    nib(b[7:4]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge mii_clk);
      mii_dv = 1'b0;
      mii_d  = 4'h0;
    end
  endtask

  task automatic clear_counts();
    mii_cnt = 0; sys_cnt = 0; sys_max_run = 0;
  endtask

  // Frame: optional delimiter, hdr_n header bytes, two type bytes, tail of repeated 88 F7 pairs
  task automatic frame(input bit with_sfd, input int hdr_n, input logic [7:0] t0,
                       input logic [7:0] t1, input bit swap, input int tail_pairs,
                       input bit exp_hit, input string req);
    clear_counts();
    for (int i = 0; i < 7; i++) nib(4'h5);
    if (with_sfd) begin nib(4'h5); nib(4'hD); end
    for (int i = 0; i < hdr_n; i++) byte_out(8'hA0 + 8'(i));
    byte_out(t0);
    if (swap) begin nib(t1[7:4]); nib(t1[3:0]); end
    else byte_out(t1);
    if (exp_hit) begin
      @(negedge mii_clk);
      mii_d = 4'h3;
      check({req, " R5 pulse after last type nibble"}, int'(pulse_mii), 1);
      @(negedge mii_clk);
      check({req, " R5 pulse one cycle"}, int'(pulse_mii), 0);
    end
    for (int i = 0; i < tail_pairs; i++) begin byte_out(8'h88); byte_out(8'hF7); end
    idle(6);
    check({req, " mii pulses"}, mii_cnt, exp_hit ? 1 : 0);
    check({req, " R9 sys pulses"}, sys_cnt, exp_hit ? 1 : 0);
    check({req, " R9 sys width"}, sys_max_run, exp_hit ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R1 mii out in reset", int'(pulse_mii), 0);
    check("R1 sys out in reset", int'(pulse_sys), 0);
    rst_n = 1'b1;
    idle(3);
    check("R1 mii out after reset", int'(pulse_mii), 0);
    check("R1 sys out after reset", int'(pulse_sys), 0);
  endtask

  task automatic t_good();
    frame(1'b1, 12, 8'h88, 8'hF7, 1'b0, 0, 1'b1, "R5 good frame");
  endtask

  task automatic t_no_sfd();
    frame(1'b0, 12, 8'h88, 8'hF7, 1'b0, 0, 1'b0, "R2 no delimiter");
  endtask

  task automatic t_swap();
    frame(1'b1, 12, 8'h88, 8'hF7, 1'b1, 0, 1'b0, "R3 nibble order");
  endtask

  task automatic t_offset();
    frame(1'b1, 11, 8'h88, 8'hF7, 1'b0, 0, 1'b0, "R4 offset 11");
    frame(1'b1, 13, 8'h88, 8'hF7, 1'b0, 0, 1'b0, "R4 offset 13");
  endtask

  task automatic t_mismatch();
    frame(1'b1, 12, 8'h89, 8'hF7, 1'b0, 2, 1'b0, "R7 first type byte");
    frame(1'b1, 12, 8'h88, 8'hF6, 1'b0, 2, 1'b0, "R7 second type byte");
  endtask

  task automatic t_repeat();
    frame(1'b1, 12, 8'h88, 8'hF7, 1'b0, 3, 1'b1, "R6 repeated type");
  endtask

  task automatic t_gap();
    clear_counts();
    for (int i = 0; i < 7; i++) nib(4'h5);
    nib(4'h5); nib(4'hD);
    for (int i = 0; i < 6; i++) byte_out(8'hA0 + 8'(i));
    idle(1);
    for (int i = 6; i < 12; i++) byte_out(8'hA0 + 8'(i));
    byte_out(8'h88); byte_out(8'hF7);
    idle(6);
    check("R8 gap suppresses pulse", mii_cnt, 0);
    check("R8 gap no sys pulse", sys_cnt, 0);
    frame(1'b1, 12, 8'h88, 8'hF7, 1'b0, 0, 1'b1, "R8 frame after gap");
  endtask

  initial begin
    idle(2);
    t_reset();
    t_good();
    t_no_sfd();
    t_swap();
    t_offset();
    t_mismatch();
    t_repeat();
    t_gap();
    t_good();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * CLK_PERIOD);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule